// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block is an SPI target that answers the manufacturer/device identification request of a serial NOR flash, and no other request. The host frames each transaction with an active-low chip select and clocks in mode 0. The block shifts in an 8-bit command and a 24-bit address on rising SCLK edges. When the command is the identification opcode, it returns two identification bytes on MISO. It is meant to stand in for a flash part in a system model, or to let a boot path that probes the flash identity run without a real device.

SCLK, chip select and MOSI are asynchronous to the block. Each is passed through a two-flop synchronizer into the system clock domain, and the block works on the edges of the synchronized SCLK. For every frame, two status outputs keep the most recent complete command byte and the most recent complete address, so the surrounding logic can observe what the host asked for.

Top module: `spi_id_target`

## Requirements
- R1: While chip select is low, MOSI is taken on each rising SCLK edge, most significant bit first. The first 8 bits form the command and the next 24 bits form the address. MISO changes only after a falling SCLK edge or a chip-select release.
- R2: `lastOpcode` takes the command byte after the 8th rising edge of a frame. `lastAddr` takes the address after the 32nd rising edge. Both outputs are zero after reset.
- R3: When the command is 0x90 and the address is not 0x000001, MISO carries the manufacturer byte and then the device byte, each most significant bit first. The first bit is driven after the falling edge that follows the 32nd rising edge.
- R4: With the default parameters, the manufacturer byte is 0xEF and the device byte is 0x14.
- R5: When the address is exactly 0x000001, the device byte is sent before the manufacturer byte. Every other address, 0x000002 included, gives the normal order.
- R6: When the command is not 0x90, MISO stays 1 for the rest of the frame. The command byte is still reported on `lastOpcode`.
- R7: When SCLK keeps toggling after the second identification byte, the two bytes repeat in the same order for as long as chip select stays low.
- R8: A rising chip select at any point ends the frame and clears the bit position. A frame cut short before its 32nd bit leaves `lastAddr` unchanged, and the next frame decodes normally.
- R9: MISO is 1 while chip select is high and after reset.
- R10: The three SPI inputs are synchronized with two flops each. Correct replies need a system clock at least ten times the SCLK rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI serial clock from the host, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host, 1 when idle |
| lastOpcode | output | 8 | Most recent complete command byte |
| lastAddr | output | 24 | Most recent complete 24-bit address |

## Verification
A pin change reaches the synchronized domain two system clocks later, and the edge detector reports it in that same cycle. MISO is therefore registered within four system clocks of a falling SCLK edge, counting the uncertainty of the asynchronous sampling. The bench drives SCLK with a half period of eight system clocks, or five for the minimum-ratio case. It samples MISO in the last falling system-clock edge before it raises SCLK, which is the moment a host samples. The status outputs are read twelve system clocks after chip select rises, well after the final rising edge has passed through the synchronizer.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
  localparam int OP_BITS   = 8;
  localparam int ADDR_BITS = 24;
  localparam int HDR_BITS  = OP_BITS + ADDR_BITS;
  localparam int ID_BYTE   = 8;
  localparam int ID_BITS   = 2 * ID_BYTE;
  localparam int CNT_W     = $clog2(HDR_BITS + 1);
  localparam int IDX_W     = $clog2(ID_BITS);

  // Strobes from control to datapath, one system clock wide.
  typedef struct packed {
    logic shiftEn;   // rising SCLK inside the header: take one MOSI bit
    logic opDone;    // this shift completes the command byte
    logic addrDone;  // this shift completes the address
    logic driveEn;   // falling SCLK in the reply phase: present next MISO bit
    logic clear;     // chip select high: abandon the frame
  } ctrlStrb_t;
endpackage

// File: rtl/spi_id_sync.sv
module spi_id_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/spi_id_ctrl.sv
module spi_id_ctrl
  import spi_id_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkS,
  input  logic             csNS,
  output ctrlStrb_t        strb,
  output logic             hdrDone,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_BITS);

  logic sclkPrev;
  logic sclkRise;
  logic sclkFall;
  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign active   = ~csNS;
  assign hdrDone  = (bitCnt == HDR_END);

  always_comb begin
    strb          = '0;
    strb.clear    = ~active;
    strb.shiftEn  = sclkRise & active & ~hdrDone;
    strb.opDone   = strb.shiftEn & (bitCnt == OP_LAST);
    strb.addrDone = strb.shiftEn & (bitCnt == HDR_LAST);
    strb.driveEn  = sclkFall & active & hdrDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (strb.clear)   bitCnt <= '0;
    else if (strb.shiftEn) bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/spi_id_dp.sv
module spi_id_dp
  import spi_id_pkg::*;
#(
  parameter logic [7:0]  MANUF_ID  = 8'hEF,
  parameter logic [7:0]  DEVICE_ID = 8'h14,
  parameter logic [7:0]  ID_OPCODE = 8'h90,
  parameter logic [23:0] SWAP_ADDR = 24'h000001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic                 mosiS,
  output logic                 misoOut,
  output logic                 cmdMatch,
  output logic [OP_BITS-1:0]   lastOpcode,
  output logic [ADDR_BITS-1:0] lastAddr
);
  logic [HDR_BITS-1:0]  shiftReg;
  logic [HDR_BITS-1:0]  shiftNext;
  logic                 swapOrder;
  logic [IDX_W-1:0]     outIdx;
  logic [ID_BITS-1:0]   idWord;

  assign shiftNext = {shiftReg[HDR_BITS-2:0], mosiS};
  assign idWord    = swapOrder ? {DEVICE_ID, MANUF_ID} : {MANUF_ID, DEVICE_ID};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.clear)   shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= shiftNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOpcode <= '0;
      cmdMatch   <= 1'b0;
    end else if (strb.clear) begin
      cmdMatch   <= 1'b0;
    end else if (strb.opDone) begin
      lastOpcode <= shiftNext[OP_BITS-1:0];
      cmdMatch   <= (shiftNext[OP_BITS-1:0] == ID_OPCODE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr  <= '0;
      swapOrder <= 1'b0;
    end else if (strb.clear) begin
      swapOrder <= 1'b0;
    end else if (strb.addrDone) begin
      lastAddr  <= shiftNext[ADDR_BITS-1:0];
      swapOrder <= (shiftNext[ADDR_BITS-1:0] == SWAP_ADDR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outIdx  <= '0;
      misoOut <= 1'b1;
    end else if (strb.clear) begin
      outIdx  <= '0;
      misoOut <= 1'b1;
    end else if (strb.driveEn) begin
      outIdx  <= outIdx + 1'b1;
      misoOut <= cmdMatch ? idWord[IDX_W'(ID_BITS - 1) - outIdx] : 1'b1;
    end
  end
endmodule

// File: rtl/spi_id_target.sv
module spi_id_target
  import spi_id_pkg::*;
#(
  parameter logic [7:0]  MANUF_ID  = 8'hEF,
  parameter logic [7:0]  DEVICE_ID = 8'h14,
  parameter logic [7:0]  ID_OPCODE = 8'h90,
  parameter logic [23:0] SWAP_ADDR = 24'h000001,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSclk,
  input  logic        spiCsN,
  input  logic        spiMosi,
  output logic        spiMiso,
  output logic [7:0]  lastOpcode,
  output logic [23:0] lastAddr
);
  logic [2:0]       pinSync;
  logic             sclkS;
  logic             csNS;
  logic             mosiS;
  ctrlStrb_t        strb;
  logic             hdrDone;
  logic [CNT_W-1:0] bitCnt;
  logic             cmdMatch;

  spi_id_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiMosi, spiCsN, spiSclk}),
    .syncOut(pinSync)
  );
  assign sclkS = pinSync[0];
  assign csNS  = pinSync[1];
  assign mosiS = pinSync[2];

  spi_id_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .csNS(csNS),
    .strb(strb), .hdrDone(hdrDone), .bitCnt(bitCnt)
  );

  spi_id_dp #(
    .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID),
    .ID_OPCODE(ID_OPCODE), .SWAP_ADDR(SWAP_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(mosiS),
    .misoOut(spiMiso), .cmdMatch(cmdMatch),
    .lastOpcode(lastOpcode), .lastAddr(lastAddr)
  );
endmodule

// File: rtl/spi_id_checker.sv
module spi_id_checker
  import spi_id_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             csNS,
  input ctrlStrb_t        strb,
  input logic             hdrDone,
  input logic             cmdMatch,
  input logic [CNT_W-1:0] bitCnt,
  input logic             spiMiso,
  input logic [7:0]       lastOpcode,
  input logic [23:0]      lastAddr
);
  // R1: MISO moves only on a falling-edge strobe or a frame clear
  p_miso_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.driveEn) && !$past(strb.clear)) |-> $stable(spiMiso));

  // R2: the status registers change only on their completion strobes
  p_opcode_upd_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastOpcode) |-> $past(strb.opDone));
  p_addr_upd_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastAddr) |-> $past(strb.addrDone));

  // R6: with no matching command the reply phase keeps MISO high
  p_bad_cmd_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hdrDone && !cmdMatch && $past(hdrDone) && !$past(cmdMatch)) |=> spiMiso);

  // R8: a released chip select empties the bit position
  p_clear_cnt_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(csNS) |-> (bitCnt == '0));
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(HDR_BITS));

  // R9: MISO is released while chip select is high
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(csNS) |-> spiMiso);

  // R1: the control never shifts and drives in the same cycle
  p_strb_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.shiftEn, strb.driveEn, strb.clear}) <= 1);
endmodule

bind spi_id_target spi_id_checker chk_i (
  .clk(clk), .rstN(rstN), .csNS(csNS), .strb(strb), .hdrDone(hdrDone),
  .cmdMatch(cmdMatch), .bitCnt(bitCnt), .spiMiso(spiMiso),
  .lastOpcode(lastOpcode), .lastAddr(lastAddr)
);

// File: tb/spi_id_target_tb_top.sv
module spi_id_target_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiSclk = 1'b0;
  logic        spiCsN = 1'b1;
  logic        spiMosi = 1'b0;
  logic        spiMiso;
  logic [7:0]  lastOpcode;
  logic [23:0] lastAddr;

  int checks = 0;
  int errors = 0;
  int halfCyc = 8;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_id_target dut_i (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso),
    .lastOpcode(lastOpcode), .lastAddr(lastAddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One framed transfer of nBits clocks; MISO is captured before each rise from bit 32 on.
  task automatic runFrame(input logic [7:0] op, input logic [23:0] ad,
                          input int nBits, output logic [63:0] rx);
    logic [31:0] hdr;
    hdr = {op, ad};
    rx = '0;
    spiCsN = 1'b0;
    waitClk(halfCyc);
    for (int i = 0; i < nBits; i++) begin
      spiMosi = (i < 32) ? hdr[31-i] : 1'b0;
      waitClk(halfCyc);
      if (i >= 32) rx = {rx[62:0], spiMiso};
      spiSclk = 1'b1;
      waitClk(halfCyc);
      spiSclk = 1'b0;
    end
    waitClk(halfCyc);
    spiCsN = 1'b1;
    waitClk(12);
  endtask

  task automatic testReset();
    check("R9 miso after reset", 64'(spiMiso), 64'h1);
    check("R2 opcode after reset", 64'(lastOpcode), 64'h0);
    check("R2 addr after reset", 64'(lastAddr), 64'h0);
  endtask

  task automatic testIdRead();
    logic [63:0] rx;
    runFrame(8'h90, 24'h000000, 48, rx);
    check("R3 R4 manufacturer then device", 64'(rx[15:0]), 64'hEF14);
    check("R2 opcode recorded", 64'(lastOpcode), 64'h90);
    check("R2 addr recorded", 64'(lastAddr), 64'h0);
    check("R9 miso high after frame", 64'(spiMiso), 64'h1);
  endtask

  task automatic testBitOrder();
    logic [63:0] rx;
    runFrame(8'h90, 24'hA5C33C, 48, rx);
    check("R1 address MSB first", 64'(lastAddr), 64'hA5C33C);
    check("R3 order with other address", 64'(rx[15:0]), 64'hEF14);
  endtask

  task automatic testSwap();
    logic [63:0] rx;
    runFrame(8'h90, 24'h000001, 48, rx);
    check("R5 swapped order at address 1", 64'(rx[15:0]), 64'h14EF);
    runFrame(8'h90, 24'h000002, 48, rx);
    check("R5 normal order at address 2", 64'(rx[15:0]), 64'hEF14);
  endtask

  task automatic testBadOpcode();
    logic [63:0] rx;
    runFrame(8'h9F, 24'h000000, 48, rx);
    check("R6 miso high for other command", 64'(rx[15:0]), 64'hFFFF);
    check("R6 other command recorded", 64'(lastOpcode), 64'h9F);
  endtask

  task automatic testRepeat();
    logic [63:0] rx;
    runFrame(8'h90, 24'h000000, 80, rx);
    check("R7 bytes repeat", 64'(rx[47:0]), 64'hEF14EF14EF14);
  endtask

  task automatic testAbort();
    logic [63:0] rx;
    runFrame(8'h90, 24'h000055, 48, rx);
    check("R2 addr before abort", 64'(lastAddr), 64'h55);
    runFrame(8'h3B, 24'h123456, 20, rx);
    check("R8 addr kept on short frame", 64'(lastAddr), 64'h55);
    check("R8 opcode of short frame", 64'(lastOpcode), 64'h3B);
    check("R9 miso high after abort", 64'(spiMiso), 64'h1);
    runFrame(8'h90, 24'h000001, 40, rx);
    check("R8 clean frame after abort", 64'(rx[7:0]), 64'h14);
    runFrame(8'h90, 24'h000000, 44, rx);
    check("R8 mid-reply abort then fresh frame", 64'(rx[11:0]), 64'hEF1);
    runFrame(8'h90, 24'h000000, 48, rx);
    check("R8 reply restarts at first bit", 64'(rx[15:0]), 64'hEF14);
  endtask

  task automatic testMinRatio();
    logic [63:0] rx;
    halfCyc = 5;
    runFrame(8'h90, 24'h000001, 48, rx);
    check("R10 reply at tenfold clock ratio", 64'(rx[15:0]), 64'h14EF);
    halfCyc = 8;
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    testReset();
    testIdRead();
    testBitOrder();
    testSwap();
    testBadOpcode();
    testRepeat();
    testAbort();
    testMinRatio();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule